// File: doc/BRIEF.md
# Clock Loss Monitor with Safe-Mode Fallback

This block runs from a free-running reference clock and watches a set of other clocks. Each of them arrives as a toggle signal. On every reference cycle the block checks whether each watched clock has changed level recently. A clock that stays silent for longer than a programmable number of reference cycles is judged dead. Any dead clock moves the device into a slow-clock safe mode, and that mode holds until a global reset. Watched clock 0 is the host bus clock, and its loss gets special treatment. A DMA transfer that is running when the bus clock dies is cut off at once with a one-cycle abort strobe. If a different clock dies, the running DMA transfer is allowed to finish, and safe mode is entered only after that.

A separate channel watches the receive clock, but only while carrier sense is high. If the receive clock stays silent for the receive window while carrier is present, the block raises a device reset request. That request also holds until a global reset.

Top module: `clock_health_monitor`

## Requirements
- R1: After reset, `slowMode`, `abortDma` and `resetReq` are all low.
- R2: A watched clock that changes level at least once every CLK_TIMEOUT reference cycles never causes `slowMode`.
- R3: When a watched clock stops, `slowMode` rises no sooner than CLK_TIMEOUT+1 and no later than CLK_TIMEOUT+5 reference cycles after its last level change.
- R4: Bit 0 of `monClkTog` is the host bus clock. If it fails while `dmaBusy` is high, `abortDma` pulses high for exactly one cycle, in the same cycle that `slowMode` rises.
- R5: If any other watched clock fails while `dmaBusy` is high, `slowMode` stays low and `abortDma` never pulses while `dmaBusy` stays high. `slowMode` rises on the first clock edge after `dmaBusy` falls.
- R6: A clock failure while `dmaBusy` is low enters `slowMode` without any `abortDma` pulse.
- R7: With `carrierSense` high, a receive clock that stays silent makes `resetReq` rise no sooner than RX_TIMEOUT+1 and no later than RX_TIMEOUT+6 reference cycles after its last level change.
- R8: While `carrierSense` is low, receive clock silence is ignored. The silence window starts only once carrier is high again, so `resetReq` follows about RX_TIMEOUT+4 cycles after carrier rises.
- R9: Once `slowMode` or `resetReq` is high, it stays high even if the clocks resume. Only `rstN` clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| refClk | input | 1 | Free-running reference clock |
| rstN | input | 1 | Asynchronous active-low global reset |
| monClkTog | input | NUM_CLKS | Level of each watched clock; bit 0 is the host bus clock |
| dmaBusy | input | 1 | A DMA transfer is in progress (reference domain) |
| rxClkTog | input | 1 | Level of the receive clock |
| carrierSense | input | 1 | Carrier present on the receive medium |
| slowMode | output | 1 | Sticky request for slow-clock safe mode |
| abortDma | output | 1 | One-cycle strobe that terminates the running DMA transfer |
| resetReq | output | 1 | Sticky device reset request after receive clock loss |

## Verification
The assertions assume that `dmaBusy` is synchronous to `refClk`. They also assume that each watched clock changes level no more often than once every two reference cycles, so that no level change is lost in the synchronizer. The stimulus drives every input on the falling reference edge. Its watched clocks hold each level for at least three reference cycles. The receive clock changes level every ten reference cycles. Clock failures are created by freezing a toggle, and `dmaBusy` is released only on a falling edge. The timing checks use windows that allow for the freeze landing anywhere inside a clock's half-period.

// File: rtl/clkmon_pkg.sv
package clkmon_pkg;

  typedef struct packed {
    logic busFail;
    logic otherFail;
    logic rxLost;
  } monStatus_t;

  typedef struct packed {
    logic freezeMon;
  } ctrlStrobe_t;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_DRAIN = 2'd1,
    ST_SAFE  = 2'd2
  } ctrlState_t;

endpackage

// File: rtl/clkmon_edge_timer.sv
module clkmon_edge_timer #(
  parameter int LIMIT       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic refClk,
  input  logic rstN,
  input  logic togIn,
  input  logic qualify,
  input  logic hold,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 2);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   lastQ;
  logic [CW-1:0]          cnt;
  logic                   edgeSeen;

  assign edgeSeen = syncQ[SYNC_STAGES-1] ^ lastQ;
  assign expired  = (cnt > CW'(LIMIT));

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
      lastQ <= 1'b0;
      cnt   <= '0;
    end else begin
      syncQ <= {syncQ[SYNC_STAGES-2:0], togIn};
      lastQ <= syncQ[SYNC_STAGES-1];
      if (!hold) begin
        if (!qualify || edgeSeen) begin
          cnt <= '0;
        end else if (cnt <= CW'(LIMIT)) begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  AST_QUALIFY_GATES: assert property (@(posedge refClk) disable iff (!rstN)
    (!qualify && !hold) |=> !expired); // R8

endmodule

// File: rtl/clkmon_datapath.sv
module clkmon_datapath
  import clkmon_pkg::*;
#(
  parameter int NUM_CLKS    = 3,
  parameter int BUS_IDX     = 0,
  parameter int CLK_TIMEOUT = 16,
  parameter int RX_TIMEOUT  = 100
) (
  input  logic                refClk,
  input  logic                rstN,
  input  logic [NUM_CLKS-1:0] monClkTog,
  input  logic                rxClkTog,
  input  logic                carrierSense,
  input  ctrlStrobe_t         strobe,
  output monStatus_t          status
);
  localparam logic [NUM_CLKS-1:0] BUS_MASK = NUM_CLKS'(1) << BUS_IDX;

  logic [NUM_CLKS-1:0] clkDead;
  logic [1:0]          carrierSync;
  logic                rxDead;

  for (genvar g = 0; g < NUM_CLKS; g++) begin : gen_mon
    clkmon_edge_timer #(.LIMIT(CLK_TIMEOUT), .SYNC_STAGES(2)) u_timer (
      .refClk (refClk),
      .rstN   (rstN),
      .togIn  (monClkTog[g]),
      .qualify(1'b1),
      .hold   (strobe.freezeMon),
      .expired(clkDead[g])
    );
  end

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) carrierSync <= '0;
    else       carrierSync <= {carrierSync[0], carrierSense};
  end

  clkmon_edge_timer #(.LIMIT(RX_TIMEOUT), .SYNC_STAGES(2)) u_rxTimer (
    .refClk (refClk),
    .rstN   (rstN),
    .togIn  (rxClkTog),
    .qualify(carrierSync[1]),
    .hold   (1'b0),
    .expired(rxDead)
  );

  assign status.busFail   = |(clkDead & BUS_MASK);
  assign status.otherFail = |(clkDead & ~BUS_MASK);
  assign status.rxLost    = rxDead;

endmodule

// File: rtl/clkmon_control.sv
module clkmon_control
  import clkmon_pkg::*;
(
  input  logic        refClk,
  input  logic        rstN,
  input  logic        dmaBusy,
  input  monStatus_t  status,
  output ctrlStrobe_t strobe,
  output logic        slowMode,
  output logic        abortDma,
  output logic        resetReq
);
  ctrlState_t state, nextState;
  logic       abortNext;

  always_comb begin
    nextState = state;
    abortNext = 1'b0;
    case (state)
      ST_RUN: begin
        if (status.busFail) begin
          nextState = ST_SAFE;
          abortNext = dmaBusy;
        end else if (status.otherFail) begin
          nextState = dmaBusy ? ST_DRAIN : ST_SAFE;
        end
      end
      ST_DRAIN: begin
        if (status.busFail) begin
          nextState = ST_SAFE;
          abortNext = dmaBusy;
        end else if (!dmaBusy) begin
          nextState = ST_SAFE;
        end
      end
      ST_SAFE: nextState = ST_SAFE;
      default: nextState = ST_SAFE;
    endcase
  end

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_RUN;
      abortDma <= 1'b0;
      resetReq <= 1'b0;
    end else begin
      state    <= nextState;
      abortDma <= abortNext;
      resetReq <= resetReq | status.rxLost;
    end
  end

  assign slowMode = (state == ST_SAFE);
  assign strobe   = '{freezeMon: slowMode};

  AST_ABORT_WITH_SLOW: assert property (@(posedge refClk) disable iff (!rstN)
    abortDma |-> slowMode); // R4
  AST_ABORT_PULSE: assert property (@(posedge refClk) disable iff (!rstN)
    abortDma |=> !abortDma); // R4
  AST_ABORT_NEEDS_BUSY: assert property (@(posedge refClk) disable iff (!rstN)
    abortDma |-> $past(dmaBusy)); // R6
  AST_BUS_FAIL_ABORTS: assert property (@(posedge refClk) disable iff (!rstN)
    (!slowMode && status.busFail && dmaBusy) |=> abortDma); // R4
  AST_DRAIN_HOLDS: assert property (@(posedge refClk) disable iff (!rstN)
    (state == ST_DRAIN && dmaBusy && !status.busFail) |=> (!slowMode && !abortDma)); // R5
  AST_SLOW_STICKY: assert property (@(posedge refClk) disable iff (!rstN)
    slowMode |=> slowMode); // R9
  AST_RESET_STICKY: assert property (@(posedge refClk) disable iff (!rstN)
    resetReq |=> resetReq); // R9

endmodule

// File: rtl/clock_health_monitor.sv
module clock_health_monitor
  import clkmon_pkg::*;
#(
  parameter int NUM_CLKS    = 3,
  parameter int BUS_IDX     = 0,
  parameter int CLK_TIMEOUT = 16,
  parameter int RX_TIMEOUT  = 100
) (
  input  logic                refClk,
  input  logic                rstN,
  input  logic [NUM_CLKS-1:0] monClkTog,
  input  logic                dmaBusy,
  input  logic                rxClkTog,
  input  logic                carrierSense,
  output logic                slowMode,
  output logic                abortDma,
  output logic                resetReq
);
  monStatus_t  status;
  ctrlStrobe_t strobe;

  clkmon_datapath #(
    .NUM_CLKS   (NUM_CLKS),
    .BUS_IDX    (BUS_IDX),
    .CLK_TIMEOUT(CLK_TIMEOUT),
    .RX_TIMEOUT (RX_TIMEOUT)
  ) u_datapath (
    .refClk      (refClk),
    .rstN        (rstN),
    .monClkTog   (monClkTog),
    .rxClkTog    (rxClkTog),
    .carrierSense(carrierSense),
    .strobe      (strobe),
    .status      (status)
  );

  clkmon_control u_control (
    .refClk  (refClk),
    .rstN    (rstN),
    .dmaBusy (dmaBusy),
    .status  (status),
    .strobe  (strobe),
    .slowMode(slowMode),
    .abortDma(abortDma),
    .resetReq(resetReq)
  );

endmodule

// File: tb/clock_health_monitor_bench.sv
module clock_health_monitor_bench;
  localparam int NCLK = 3;

  logic            refClk = 1'b0;
  logic            rstN = 1'b0;
  logic [NCLK-1:0] monClkTog = '0;
  logic            dmaBusy = 1'b0;
  logic            rxClkTog = 1'b0;
  logic            carrierSense = 1'b1;
  logic            slowMode, abortDma, resetReq;

  clock_health_monitor u_clock_health_monitor (
    .refClk(refClk), .rstN(rstN), .monClkTog(monClkTog), .dmaBusy(dmaBusy),
    .rxClkTog(rxClkTog), .carrierSense(carrierSense),
    .slowMode(slowMode), .abortDma(abortDma), .resetReq(resetReq)
  );

  always #10 refClk = ~refClk;

  int  halfPer [NCLK] = '{3, 5, 8};
  bit  runClk  [NCLK] = '{1'b1, 1'b1, 1'b1};
  bit  rxRun = 1'b1;
  int  genCnt = 0;

  always @(negedge refClk) begin
    genCnt <= genCnt + 1;
    for (int i = 0; i < NCLK; i++)
      if (runClk[i] && (genCnt % halfPer[i] == 0)) monClkTog[i] <= ~monClkTog[i];
    if (rxRun && (genCnt % 10 == 0)) rxClkTog <= ~rxClkTog;
  end

  typedef struct {
    int    at;
    bit    slow;
    int    aborts;
    bit    rst;
    string req;
  } expItem_t;

  expItem_t sbQ[$];
  int  cyc = 0;
  int  abortCnt = 0;
  int  checks = 0;
  int  fails = 0;
  bit  done = 1'b0;

  task automatic expectIn(int delta, bit s, int a, bit r, string req);
    expItem_t it;
    it.at = cyc + delta; it.slow = s; it.aborts = a; it.rst = r; it.req = req;
    sbQ.push_back(it);
  endtask

  task automatic waitCyc(int n);
    repeat (n) @(negedge refClk);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    dmaBusy = 1'b0;
    carrierSense = 1'b1;
    rxRun = 1'b1;
    for (int i = 0; i < NCLK; i++) runClk[i] = 1'b1;
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(2);
  endtask

  // monitor: samples 5 ns after each rising edge and compares with the scoreboard
  always begin
    expItem_t it;
    @(posedge refClk);
    #5;
    cyc++;
    if (!rstN) abortCnt = 0;
    else if (abortDma) abortCnt++;
    while (sbQ.size() > 0 && sbQ[0].at <= cyc) begin
      it = sbQ.pop_front();
      checks++;
      if (slowMode !== it.slow || abortCnt != it.aborts || resetReq !== it.rst) begin
        fails++;
        $display("FAIL %s: got slow=%0b aborts=%0d rst=%0b, expected slow=%0b aborts=%0d rst=%0b",
                 it.req, slowMode, abortCnt, resetReq, it.slow, it.aborts, it.rst);
      end
    end
  end

  initial begin
    // R1: state right after reset
    doReset();
    expectIn(1, 0, 0, 0, "R1 reset state");
    waitCyc(3);
    // R2: all clocks running with different half-periods
    expectIn(50, 0, 0, 0, "R2 healthy clocks");
    expectIn(300, 0, 0, 0, "R2 healthy clocks long");
    waitCyc(302);
    // R3/R6: non-bus clock 1 stops, no DMA
    runClk[1] = 1'b0;
    expectIn(12, 0, 0, 0, "R3 not before window");
    expectIn(30, 1, 0, 0, "R3 R6 slow mode after window");
    waitCyc(32);
    runClk[1] = 1'b1;
    waitCyc(50);
    expectIn(1, 1, 0, 0, "R9 slow mode sticky after clock resumes");
    waitCyc(3);
    // R4: bus clock dies during DMA
    doReset();
    dmaBusy = 1'b1;
    runClk[0] = 1'b0;
    expectIn(12, 0, 0, 0, "R4 no early abort");
    expectIn(30, 1, 1, 0, "R4 single abort pulse with slow mode");
    waitCyc(32);
    dmaBusy = 1'b0;
    // R6: bus clock dies with DMA idle
    doReset();
    runClk[0] = 1'b0;
    expectIn(30, 1, 0, 0, "R6 bus failure without DMA");
    waitCyc(32);
    // R5: clock 2 dies during DMA, transfer allowed to finish
    doReset();
    dmaBusy = 1'b1;
    runClk[2] = 1'b0;
    expectIn(30, 0, 0, 0, "R5 waits for DMA");
    expectIn(60, 0, 0, 0, "R5 still waiting");
    waitCyc(60);
    dmaBusy = 1'b0;
    expectIn(2, 1, 0, 0, "R5 slow mode after DMA done");
    waitCyc(4);
    // R7: receive clock lost with carrier
    doReset();
    rxRun = 1'b0;
    expectIn(85, 0, 0, 0, "R7 not before window");
    expectIn(115, 0, 0, 1, "R7 reset request");
    waitCyc(117);
    rxRun = 1'b1;
    waitCyc(30);
    expectIn(1, 0, 0, 1, "R9 reset request sticky");
    waitCyc(3);
    // R8: silence without carrier is ignored
    doReset();
    carrierSense = 1'b0;
    rxRun = 1'b0;
    expectIn(300, 0, 0, 0, "R8 ignored without carrier");
    waitCyc(300);
    carrierSense = 1'b1;
    expectIn(90, 0, 0, 0, "R8 window starts at carrier");
    expectIn(115, 0, 0, 1, "R8 reset request after carrier");
    waitCyc(117);
    // R1: reset clears sticky outputs
    doReset();
    expectIn(1, 0, 0, 0, "R1 reset clears sticky outputs");
    waitCyc(4);
    while (sbQ.size() > 0) waitCyc(1);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(64'd200000 * 20);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got run still active, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule